// File: doc/BRIEF.md
# Successive-Approximation Converter Control Front-End

This block is the register-level controller for a 10-bit successive-approximation converter. The analog core is absent: its digitised result arrives on a sample input, and the controller tells it which channel and reference to use. Software reaches four byte-wide registers over a simple bus with address, write data, write strobe, read strobe and read data. These are a multiplexer register, a control/status register, and the two halves of the result.

A conversion starts when software writes the control register with both enable and start set. The controller divides the system clock into a converter clock, counts out the conversion, and then stores the result and raises a completion flag. With auto-trigger set, the next conversion begins straight away. A write that clears enable stops any conversion in progress. The controller does not pass a channel or reference change to the core while a conversion is running. Reading the low result byte holds the result steady until the high byte is read, so the two halves always belong to the same conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Register offsets are 0 multiplexer, 1 control, 2 result low byte, 3 result high byte. The control byte reads {enable[7], busy/start[6], auto[5], flag[4], irq-enable[3], prescale[2:0]}. Bit 6 reads 1 from the write that starts a conversion until that conversion completes. Writing 0 to bit 6 has no effect.
- R2: The multiplexer byte reads back as written: reference in [7:6], left-adjust in [5], channel in [4:0]. A conversion taken on channel code 11111 stores a result of 0.
- R3: ch_sel and ref_sel follow the multiplexer register only while idle, or at the edge where a conversion completes. A write made during a conversion does not reach them before that conversion completes.
- R4: The first conversion after enable goes from 0 to 1 lasts 25 converter clocks. Every later conversion lasts 13.
- R5: Prescale code 0 gives a converter clock of system clock / 2. Code k (1..7) gives system clock / 2^k. Busy stays high for length × divisor system cycles after the starting write.
- R6: A control write with bit 7 = 0 clears busy at once. The aborted conversion sets no flag and stores no result.
- R7: When a conversion completes, the flag is set and the result is stored. The flag is cleared by writing 1 to bit 4 or by pulsing irq_ack. If a completion and a clear fall in the same cycle, the flag is set.
- R8: irq is high exactly when the flag and irq-enable are both 1.
- R9: With auto set, a completion starts the next conversion in the same cycle. Busy never drops, and each later conversion lasts 13 converter clocks.
- R10: A read of offset 2 locks the stored result. While it is locked, completions still set the flag but do not change the result. A read of offset 3 releases the lock.
- R11: Left-adjust acts on the read data at once. With left-adjust 1 the 16-bit data word is result << 6. With left-adjust 0 it is the result in bits 9:0, and the unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe; only affects the result lock |
| rdata | output | 8 | Read data for addr, combinational |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| sample | input | 10 | Digitised value from the analog core |
| ch_sel | output | 5 | Channel applied to the analog core |
| ref_sel | output | 2 | Reference applied to the analog core |
| irq | output | 1 | Completion interrupt |

## Verification
The checker assumes the bus delivers at most one write or read per cycle. It also assumes the prescale and auto fields are not rewritten while a conversion is running, because the conversion length depends on both. The stimulus follows these rules by changing those fields only while the controller is idle. Channel changes, by contrast, are made mid-conversion on purpose. The reference model counts elapsed cycles against length × divisor instead of following a counter, so a conversion that is cut short or drawn out shows up as a mismatch.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int FIRST_LEN = 25,
  parameter int NORM_LEN  = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  input  logic       irq_ack,
  input  logic [9:0] sample,
  output logic [4:0] ch_sel,
  output logic [1:0] ref_sel,
  output logic       irq
);
  localparam logic [4:0] FIRST_LAST = 5'(FIRST_LEN - 1);
  localparam logic [4:0] NORM_LAST  = 5'(NORM_LEN - 1);
  localparam logic [1:0] A_MUX = 2'd0, A_CTL = 2'd1, A_LO = 2'd2, A_HI = 2'd3;

  logic [7:0] mux_q;
  logic [6:0] act_q;
  logic       en, busy, auto_q, flag, ie, first, lock;
  logic [2:0] ps;
  logic [4:0] cnt;
  logic [6:0] pre;
  logic [9:0] res_q;

  logic wr_mux, wr_ctl, start, abort, tick, done;
  logic [6:0] mask;
  logic [15:0] word;

  assign wr_mux = wr && addr == A_MUX;
  assign wr_ctl = wr && addr == A_CTL;
  assign start  = wr_ctl && wdata[7] && wdata[6] && !busy;
  assign abort  = wr_ctl && !wdata[7];
  assign mask   = (ps == 3'd0) ? 7'd1 : (7'd1 << ps) - 7'd1;
  assign tick   = busy && ((pre & mask) == mask);
  assign done   = tick && cnt == (first ? FIRST_LAST : NORM_LAST);

  assign ch_sel  = act_q[4:0];
  assign ref_sel = act_q[6:5];
  assign irq     = flag & ie;
  assign word    = mux_q[5] ? {res_q, 6'b0} : {6'b0, res_q};

  always_comb begin
    case (addr)
      A_MUX:   rdata = mux_q;
      A_CTL:   rdata = {en, busy, auto_q, flag, ie, ps};
      A_LO:    rdata = word[7:0];
      default: rdata = word[15:8];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q <= '0; act_q <= '0; en <= 1'b0; busy <= 1'b0; auto_q <= 1'b0;
      flag <= 1'b0; ie <= 1'b0; ps <= '0; first <= 1'b0; lock <= 1'b0;
      cnt <= '0; pre <= '0; res_q <= '0;
    end else begin
      if (wr_mux) mux_q <= wdata;
      if (!busy || done) act_q <= {mux_q[7:6], mux_q[4:0]};

      if (wr_ctl) begin
        en     <= wdata[7];
        auto_q <= wdata[5];
        ie     <= wdata[3];
        ps     <= wdata[2:0];
        if (wdata[7] && !en) first <= 1'b1;
      end

      if (done && !abort) flag <= 1'b1;
      else if (irq_ack || (wr_ctl && wdata[4])) flag <= 1'b0;

      if (abort) begin
        busy <= 1'b0;
        cnt  <= '0;
        pre  <= '0;
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        pre  <= '0;
      end else if (busy) begin
        pre <= pre + 7'd1;
        if (tick) cnt <= cnt + 5'd1;
        if (done) begin
          first <= 1'b0;
          cnt   <= '0;
          pre   <= '0;
          busy  <= auto_q;
        end
      end

      if (done && !abort && !lock)
        res_q <= (act_q[4:0] == 5'h1f) ? 10'd0 : sample;

      if (rd && addr == A_LO) lock <= 1'b1;
      else if (rd && addr == A_HI) lock <= 1'b0;
    end
  end
endmodule

module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       wr,
  input logic       rd,
  input logic       irq_ack,
  input logic       busy,
  input logic       done,
  input logic       flag,
  input logic       lock,
  input logic [9:0] res_q,
  input logic [4:0] ch_sel,
  input logic [1:0] ref_sel
);
  // R1
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd1 && wdata[7] && wdata[6]) |=> busy);
  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(ch_sel) && $stable(ref_sel)));
  // R6
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd1 && !wdata[7]) |=> !busy);
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(wr && addr == 2'd1 && !wdata[7])) |=> flag);
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !done) |=> !flag);
  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !(rd && addr == 2'd3)) |=> $stable(res_q));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
  .irq_ack(irq_ack), .busy(busy), .done(done), .flag(flag), .lock(lock),
  .res_q(res_q), .ch_sel(ch_sel), .ref_sel(ref_sel)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0, irq_ack = 1'b0;
  logic [9:0] sample = '0;
  logic [7:0] rdata;
  logic [4:0] ch_sel;
  logic [1:0] ref_sel;
  logic       irq;

  int vecs = 0, errs = 0;

  adc_seq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata), .irq_ack(irq_ack), .sample(sample),
    .ch_sel(ch_sel), .ref_sel(ref_sel), .irq(irq));

  always #5 clk = ~clk;

  // behavioural reference model
  logic [7:0] m_mux;
  logic [6:0] m_act;
  logic       m_en, m_busy, m_auto, m_flag, m_ie, m_first, m_lock;
  logic [2:0] m_ps;
  logic [9:0] m_res;
  int         m_el;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mux = '0; m_act = '0; m_en = 0; m_busy = 0; m_auto = 0; m_flag = 0;
      m_ie = 0; m_first = 0; m_lock = 0; m_ps = '0; m_res = '0; m_el = 0;
    end else begin
      int div, len;
      logic wc, ab, st, dn;
      logic [7:0] o_mux;
      logic [6:0] o_act;
      logic o_en, o_busy, o_auto, o_lock;
      div = (m_ps == 0) ? 2 : (1 << m_ps);
      len = m_first ? 25 : 13;
      wc = wr && addr == 2'd1;
      ab = wc && !wdata[7];
      st = wc && wdata[7] && wdata[6] && !m_busy;
      dn = m_busy && (m_el == len * div - 1);
      o_mux = m_mux; o_act = m_act; o_en = m_en; o_busy = m_busy;
      o_auto = m_auto; o_lock = m_lock;
      if (!o_busy || dn) m_act = {o_mux[7:6], o_mux[4:0]};
      if (wr && addr == 2'd0) m_mux = wdata;
      if (wc) begin
        m_en = wdata[7]; m_auto = wdata[5]; m_ie = wdata[3]; m_ps = wdata[2:0];
        if (wdata[7] && !o_en) m_first = 1;
      end
      if (dn && !ab) m_flag = 1;
      else if (irq_ack || (wc && wdata[4])) m_flag = 0;
      if (ab) begin m_busy = 0; m_el = 0; end
      else if (st) begin m_busy = 1; m_el = 0; end
      else if (o_busy) begin
        m_el++;
        if (dn) begin m_first = 0; m_el = 0; m_busy = o_auto; end
      end
      if (dn && !ab && !o_lock) m_res = (o_act[4:0] == 5'h1f) ? 10'd0 : sample;
      if (rd && addr == 2'd2) m_lock = 1;
      else if (rd && addr == 2'd3) m_lock = 0;
    end
  end

  function automatic logic [7:0] exp_rdata();
    logic [15:0] w;
    w = m_mux[5] ? {m_res, 6'b0} : {6'b0, m_res};
    case (addr)
      2'd0: return m_mux;
      2'd1: return {m_en, m_busy, m_auto, m_flag, m_ie, m_ps};
      2'd2: return w[7:0];
      default: return w[15:8];
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(addr == 2'd0 ? "R2 mux readback" : addr == 2'd1 ? "R1 control readback" :
        m_mux[5] ? "R11 left data" : "R10 data", 16'(rdata), 16'(exp_rdata()));
    chk("R8 irq", 16'(irq), 16'(m_flag & m_ie));
    chk("R3 channel/reference", 16'({ref_sel, ch_sel}), 16'(m_act));
  end

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); #1 addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); #1 wr = 1'b0; addr = 2'd1;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); #1 addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); #1 rd = 1'b0; addr = 2'd1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    #1 addr = 2'd1;
    while (rdata[6] && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int n;
    idle(3);
    #1 rst_n = 1'b1;
    @(negedge clk); #1 addr = 2'd1;
    chk("R1 reset control", 16'(rdata), 16'h0);
    chk("R8 reset irq", 16'(irq), 16'h0);

    // first conversion, /2, channel 3 ref 1
    sample = 10'h2A5;
    wr_reg(2'd0, 8'h43);
    rd_reg(2'd0, b); chk("R2 mux readback", 16'(b), 16'h43);
    wr_reg(2'd1, 8'hC8);
    measure(n); chk("R4 R5 first conversion cycles", 16'(n), 16'd50);
    chk("R7 flag after completion", 16'(rdata[4]), 16'd1);
    chk("R8 irq after completion", 16'(irq), 16'd1);
    rd_reg(2'd2, b); chk("R11 right low", 16'(b), 16'hA5);
    rd_reg(2'd3, b); chk("R11 right high", 16'(b), 16'h02);
    wr_reg(2'd0, 8'h63);
    rd_reg(2'd2, b); chk("R11 left low", 16'(b), 16'h40);
    rd_reg(2'd3, b); chk("R11 left high", 16'(b), 16'hA9);

    // write-1 clear; start written 0 does nothing
    wr_reg(2'd1, 8'h98);
    chk("R7 write-one clear", 16'(rdata[4]), 16'd0);
    chk("R1 start written 0 stays idle", 16'(rdata[6]), 16'd0);

    // later conversion, code 1 (/2) then code 2 (/4)
    wr_reg(2'd1, 8'hC9);
    measure(n); chk("R4 R5 later conversion /2", 16'(n), 16'd26);
    irq_ack = 1'b1; @(negedge clk); #1 irq_ack = 1'b0;
    chk("R7 ack clears flag", 16'(rdata[4]), 16'd0);
    wr_reg(2'd1, 8'hCA);
    measure(n); chk("R5 conversion /4", 16'(n), 16'd52);

    // deferred channel change to ground
    wr_reg(2'd0, 8'h03);
    sample = 10'h155;
    wr_reg(2'd1, 8'hC8);
    wr_reg(2'd0, 8'hDF);
    chk("R3 channel held during conversion", 16'(ch_sel), 16'h03);
    measure(n);
    rd_reg(2'd2, b); chk("R3 old channel used", 16'(b), 16'h55);
    rd_reg(2'd3, b);
    chk("R3 channel applied after completion", 16'({ref_sel, ch_sel}), 16'h7F);
    wr_reg(2'd1, 8'hC8);
    measure(n);
    rd_reg(2'd2, b); chk("R2 ground low", 16'(b), 16'h00);
    rd_reg(2'd3, b); chk("R2 ground high", 16'(b), 16'h00);

    // lock
    wr_reg(2'd0, 8'h05);
    sample = 10'h3C1;
    wr_reg(2'd1, 8'hC8); measure(n);
    rd_reg(2'd2, b); chk("R10 low read", 16'(b), 16'hC1);
    sample = 10'h0F0;
    wr_reg(2'd1, 8'hC8); measure(n);
    chk("R10 flag still set while locked", 16'(rdata[4]), 16'd1);
    rd_reg(2'd3, b); chk("R10 high held", 16'(b), 16'h03);
    wr_reg(2'd1, 8'hD8); measure(n);
    rd_reg(2'd2, b); chk("R10 updated after unlock", 16'(b), 16'hF0);
    rd_reg(2'd3, b);

    // free running
    wr_reg(2'd1, 8'hE8);
    idle(120);
    chk("R9 still busy", 16'(rdata[6]), 16'd1);
    chk("R9 flag from repeats", 16'(rdata[4]), 16'd1);
    wr_reg(2'd1, 8'h08);
    chk("R6 abort clears busy", 16'(rdata[6]), 16'd0);

    // abort mid-conversion
    wr_reg(2'd1, 8'h98);
    wr_reg(2'd1, 8'hC8);
    idle(10);
    wr_reg(2'd1, 8'h08);
    idle(60);
    chk("R6 no flag after abort", 16'(rdata[4]), 16'd0);
    chk("R6 still idle", 16'(rdata[6]), 16'd0);
    wr_reg(2'd1, 8'hC8);
    measure(n); chk("R4 first again after re-enable", 16'(n), 16'd50);

    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule